// File: doc/BRIEF.md
# Flash Status Register with Repeating Serial Readout

This block holds the status flags of a serial flash device and answers the read-status command on the SPI slave port. It keeps three flags. The busy flag follows the array sequencer's busy line. The write-enable latch is set by a pulse from the write-enable command decoder and cleared by pulses from any of several command handlers. The program-error flag is raised by a failed byte program and cleared when the next program operation starts. The assembled status byte is also presented in parallel to the rest of the device.

The SPI pins are sampled on the system clock. Inside a selected frame the block shifts in an 8-bit opcode on rising SCK edges. When the opcode is 05h, the block streams the status byte out, MSB first, on its serial output. It advances one bit after each falling SCK edge that follows a consumed rising edge. After bit 0 it starts again at bit 7 with a freshly captured status byte. This continues for as long as chip select stays low, and a program or erase in progress does not stop it. Any other opcode leaves the output disabled until the frame ends. Raising chip select ends the frame at any bit and disables the output.

The frame controller has four states. `ST_IDLE` holds while chip select is high. `ST_OPCODE` collects the opcode bits. `ST_STREAM` drives status bits. `ST_SKIP` waits out a frame that carries a foreign opcode. The named transitions are:
- select, from `ST_IDLE` to `ST_OPCODE` when chip select goes low;
- match, from `ST_OPCODE` to `ST_STREAM` when the eighth opcode bit completes 05h;
- mismatch, from `ST_OPCODE` to `ST_SKIP` when the eighth bit completes any other opcode;
- release, from any state to `ST_IDLE` when chip select is high.

Top module: `flash_status_reg`

## Requirements
- R1: After reset the status byte reads 00h while the busy input is low, and the serial output enable is low.
- R2: In a frame whose first 8 bits (MSB first, captured on rising SCK) are 05h, the output enable rises and the status byte appears MSB first. Each bit is valid before the rising SCK edge that follows it, and the first bit is already valid before the ninth rising edge.
- R3: While chip select stays low, bit 0 is followed by bit 7 of the next repetition, with no gap, for any number of repetitions.
- R4: A repetition carries the status captured at its start. The first repetition is captured on the rising edge that completes the opcode, and each later one on the falling edge after bit 0. A change made after the capture shows up only in the next repetition.
- R5: The status can be read while the busy input is high, and bit 0 then reads 1.
- R6: In a frame with any opcode other than 05h, the output enable stays low and the serial output reads 0 for the whole frame.
- R7: Chip select going high at any bit position drops the output enable by the next clock, and the next frame starts with a new opcode.
- R8: A set pulse makes the write-enable latch (bit 1) read 1. A pulse on any clear line makes it read 0, and a clear wins over a set in the same cycle.
- R9: A program-fail pulse makes the error flag (bit 5) read 1, and a program-start pulse makes it read 0. A fail wins over a start in the same cycle.
- R10: The status byte has busy in bit 0, the write-enable latch in bit 1 and the error flag in bit 5. Bits 2, 3, 4, 6 and 7 always read 0.
- R11: Readout works both with SCK idling low (mode 0) and with SCK idling high when chip select falls (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial status data to the host, 0 when not enabled |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| arr_busy | input | 1 | Busy level from the array sequencer |
| wel_set | input | 1 | One-cycle pulse that sets the write-enable latch |
| wel_clr | input | N_CLR | One-cycle clear pulses, one per command handler |
| prog_start | input | 1 | One-cycle pulse when a program operation starts |
| prog_fail | input | 1 | One-cycle pulse when a byte fails to program |
| status | output | 8 | Current status byte |

## Verification
The bench uses the default build: two write-enable clear lines, an 8-bit opcode and read opcode 05h, with SCK running at one eighth of the system clock. Two clear lines are enough to show that any one line clears the latch and that a clear beats a set. With eight system clocks per SCK bit, status changes can be placed between a capture and the next rollover, so the difference between a held snapshot and a fresh repetition is visible. The same setup makes it possible to release chip select partway through a byte.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    localparam int STAT_W   = 8;
    localparam int BIT_BUSY = 0;
    localparam int BIT_WEL  = 1;
    localparam int BIT_EPE  = 5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPCODE = 2'd1,
        ST_STREAM = 2'd2,
        ST_SKIP   = 2'd3
    } rd_state_t;

endpackage

// File: rtl/fsr_edge.sv
module fsr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic rise_o,
    output logic fall_o
);

    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
        end else begin
            sck_q <= sck_i;
        end
    end

    always_comb begin
        rise_o = sck_i & ~sck_q;
        fall_o = ~sck_i & sck_q;
    end

endmodule

// File: rtl/fsr_flags.sv
module fsr_flags
    import flash_status_pkg::*;
#(
    parameter int N_CLR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              wel_set_i,
    input  logic [N_CLR-1:0]  wel_clr_i,
    input  logic              prog_start_i,
    input  logic              prog_fail_i,
    output logic [STAT_W-1:0] stat_o
);

    logic wel_q;
    logic epe_q;
    logic any_clr;

    assign any_clr = |wel_clr_i;

    // Write-enable latch: clear has priority over set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else if (any_clr) begin
            wel_q <= 1'b0;
        end else if (wel_set_i) begin
            wel_q <= 1'b1;
        end
    end

    // Error flag: a failure has priority over the start of a new program.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epe_q <= 1'b0;
        end else if (prog_fail_i) begin
            epe_q <= 1'b1;
        end else if (prog_start_i) begin
            epe_q <= 1'b0;
        end
    end

    always_comb begin
        stat_o           = '0;
        stat_o[BIT_BUSY] = busy_i;
        stat_o[BIT_WEL]  = wel_q;
        stat_o[BIT_EPE]  = epe_q;
    end

endmodule

// File: rtl/fsr_serial.sv
module fsr_serial
    import flash_status_pkg::*;
#(
    parameter int              OPC_W    = 8,
    parameter logic [OPC_W-1:0] READ_OPC = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              so_o,
    output logic              so_oe_o
);

    localparam int OCW = $clog2(OPC_W);
    localparam int BCW = $clog2(STAT_W);
    localparam logic [OCW-1:0] OPC_LAST = OCW'(OPC_W - 1);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(STAT_W - 1);

    rd_state_t         state_q, state_d;
    logic [OPC_W-1:0]  opc_sr_q;
    logic [OCW-1:0]    opc_cnt_q;
    logic [STAT_W-1:0] shreg_q;
    logic [BCW-1:0]    bit_cnt_q;
    logic              adv_q;
    logic [OPC_W-1:0]  opc_full;
    logic              opc_done;

    assign opc_full = {opc_sr_q[OPC_W-2:0], mosi_i};
    assign opc_done = (state_q == ST_OPCODE) && rise_i && (opc_cnt_q == OPC_LAST);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (cs_n_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: begin
                    if (opc_done) begin
                        state_d = (opc_full == READ_OPC) ? ST_STREAM : ST_SKIP;
                    end
                end
                ST_STREAM: state_d = ST_STREAM;
                ST_SKIP:   state_d = ST_SKIP;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // Opcode collection and status shifter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_sr_q  <= '0;
            opc_cnt_q <= '0;
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            adv_q     <= 1'b0;
        end else if (state_q != ST_OPCODE && state_q != ST_STREAM) begin
            opc_sr_q  <= '0;
            opc_cnt_q <= '0;
            bit_cnt_q <= '0;
            adv_q     <= 1'b0;
        end else if (state_q == ST_OPCODE) begin
            if (rise_i) begin
                opc_sr_q  <= opc_full;
                opc_cnt_q <= opc_cnt_q + 1'b1;
            end
            if (opc_done) begin
                shreg_q   <= stat_i;
                bit_cnt_q <= '0;
                adv_q     <= 1'b0;
            end
        end else begin
            if (rise_i) begin
                adv_q <= 1'b1;
            end else if (fall_i && adv_q) begin
                adv_q <= 1'b0;
                if (bit_cnt_q == BIT_LAST) begin
                    shreg_q   <= stat_i;
                    bit_cnt_q <= '0;
                end else begin
                    shreg_q   <= {shreg_q[STAT_W-2:0], 1'b0};
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
            end
        end
    end

    // Outputs.
    always_comb begin
        so_oe_o = (state_q == ST_STREAM);
        so_o    = so_oe_o & shreg_q[STAT_W-1];
    end

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import flash_status_pkg::*;
#(
    parameter int               N_CLR    = 2,
    parameter int               OPC_W    = 8,
    parameter logic [OPC_W-1:0] READ_OPC = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              arr_busy,
    input  logic              wel_set,
    input  logic [N_CLR-1:0]  wel_clr,
    input  logic              prog_start,
    input  logic              prog_fail,
    output logic [STAT_W-1:0] status
);

    logic sck_rise;
    logic sck_fall;

    fsr_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (spi_sck),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    fsr_flags #(.N_CLR(N_CLR)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (arr_busy),
        .wel_set_i    (wel_set),
        .wel_clr_i    (wel_clr),
        .prog_start_i (prog_start),
        .prog_fail_i  (prog_fail),
        .stat_o       (status)
    );

    fsr_serial #(.OPC_W(OPC_W), .READ_OPC(READ_OPC)) u_serial (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_i  (spi_cs_n),
        .mosi_i  (spi_mosi),
        .rise_i  (sck_rise),
        .fall_i  (sck_fall),
        .stat_i  (status),
        .so_o    (spi_miso),
        .so_oe_o (spi_miso_oe)
    );

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int N_CLR = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spi_cs_n,
    input logic             spi_miso_oe,
    input logic             wel_set,
    input logic [N_CLR-1:0] wel_clr,
    input logic             prog_start,
    input logic             prog_fail,
    input logic [7:0]       status
);

    p_cs_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> !spi_miso_oe);

    p_oe_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_miso_oe) |-> !spi_cs_n);

    p_wel_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_set && !(|wel_clr)) |=> status[1]);

    p_wel_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|wel_clr) |=> !status[1]);

    p_epe_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_fail |=> status[5]);

    p_epe_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start && !prog_fail) |=> !status[5]);

endmodule

bind flash_status_reg fsr_checker #(.N_CLR(N_CLR)) u_fsr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_oe (spi_miso_oe),
    .wel_set     (wel_set),
    .wel_clr     (wel_clr),
    .prog_start  (prog_start),
    .prog_fail   (prog_fail),
    .status      (status)
);

// File: tb/test_flash_status_reg.sv
module test_flash_status_reg;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int N_CLR      = 2;

    typedef struct packed {
        logic       busy;
        logic       wset;
        logic [1:0] wclr;
        logic       pstart;
        logic       pfail;
        logic [7:0] exp;
    } vec_t;

    // Flags accumulate from one vector to the next.
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 8'h02},  // R8 set
        '{1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h03},  // R5 busy
        '{1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 8'h23},  // R9 fail
        '{1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 8'h20},  // R8 clear line 0
        '{1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 8'h20},  // R8 clear beats set
        '{1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 8'h00},  // R9 start clears
        '{1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 8'h21},  // R9 fail beats start
        '{1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 8'h22}   // R8 set again
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             spi_cs_n = 1'b1;
    logic             spi_sck = 1'b0;
    logic             spi_mosi = 1'b0;
    logic             spi_miso;
    logic             spi_miso_oe;
    logic             arr_busy = 1'b0;
    logic             wel_set = 1'b0;
    logic [N_CLR-1:0] wel_clr = '0;
    logic             prog_start = 1'b0;
    logic             prog_fail = 1'b0;
    logic [7:0]       status;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  oe_all;
    bit  oe_any;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_reg i_flash_status_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .arr_busy    (arr_busy),
        .wel_set     (wel_set),
        .wel_clr     (wel_clr),
        .prog_start  (prog_start),
        .prog_fail   (prog_fail),
        .status      (status)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic spi_sel(input bit mode3);
        spi_sck = mode3;
        wait_h();
        spi_cs_n = 1'b0;
        wait_h();
    endtask

    task automatic spi_tx(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            spi_sck  = 1'b0;
            spi_mosi = b[i];
            wait_h();
            spi_sck = 1'b1;
            wait_h();
        end
    endtask

    task automatic spi_rx(input int nbits, output logic [7:0] v);
        v      = '0;
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            spi_sck = 1'b0;
            wait_h();
            v      = {v[6:0], spi_miso};
            oe_all = oe_all & spi_miso_oe;
            oe_any = oe_any | spi_miso_oe;
            spi_sck = 1'b1;
            wait_h();
        end
    endtask

    task automatic spi_desel(input bit mode3);
        if (!mode3) begin
            spi_sck = 1'b0;
            wait_h();
        end
        spi_cs_n = 1'b1;
        wait_h();
        spi_sck = 1'b0;
        wait_h();
    endtask

    task automatic pulse(input logic ws, input logic [1:0] wc, input logic ps, input logic pf);
        wel_set    = ws;
        wel_clr    = wc;
        prog_start = ps;
        prog_fail  = pf;
        @(negedge clk);
        wel_set    = 1'b0;
        wel_clr    = '0;
        prog_start = 1'b0;
        prog_fail  = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] rx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 status after reset", status, 8'h00);
        check("R1 output enable after reset", {7'b0, spi_miso_oe}, 8'h00);

        // Table walk: R8, R9, R10 on the parallel byte; R2, R5 on the serial readout
        for (int k = 0; k < 8; k++) begin
            arr_busy = VECS[k].busy;
            pulse(VECS[k].wset, VECS[k].wclr, VECS[k].pstart, VECS[k].pfail);
            check("R10 status layout", status, VECS[k].exp);
            spi_sel(1'b0);
            spi_tx(8'h05);
            spi_rx(8, rx);
            check("R2 serial status byte", rx, VECS[k].exp);
            check("R2 output enabled", {7'b0, oe_all}, 8'h01);
            spi_desel(1'b0);
        end

        // R3 / R4: repetitions with fresh captures; state is busy0 wel1 epe1
        spi_sel(1'b0);
        spi_tx(8'h05);
        arr_busy = 1'b1;               // after the first capture
        spi_rx(8, rx);
        check("R4 first repetition holds capture", rx, 8'h22);
        spi_rx(8, rx);
        check("R3 second repetition fresh", rx, 8'h23);
        check("R5 enabled while busy", {7'b0, oe_all}, 8'h01);
        @(negedge clk);
        pulse(1'b0, 2'b10, 1'b0, 1'b0);
        spi_rx(8, rx);
        check("R3 third repetition fresh", rx, 8'h21);
        spi_desel(1'b0);
        arr_busy = 1'b0;

        // R6 foreign opcode
        spi_sel(1'b0);
        spi_tx(8'h9F);
        spi_rx(8, rx);
        check("R6 output enable never high", {7'b0, oe_any}, 8'h00);
        check("R6 serial output zero", rx, 8'h00);
        spi_desel(1'b0);

        // R7 chip select release mid byte
        spi_sel(1'b0);
        spi_tx(8'h05);
        spi_rx(3, rx);
        check("R7 three bits before release", rx, 8'h01);
        spi_cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 output enable after release", {7'b0, spi_miso_oe}, 8'h00);
        spi_sck = 1'b0;
        wait_h();
        spi_sel(1'b0);
        spi_tx(8'h05);
        spi_rx(8, rx);
        check("R7 next frame reads again", rx, 8'h20);
        spi_desel(1'b0);

        // R11 mode 3
        arr_busy = 1'b1;
        spi_sel(1'b1);
        spi_tx(8'h05);
        spi_rx(8, rx);
        check("R11 mode 3 readout", rx, 8'h21);
        spi_rx(8, rx);
        check("R11 mode 3 repetition", rx, 8'h21);
        spi_desel(1'b1);
        arr_busy = 1'b0;

        summary();
    end

endmodule